// File: doc/BRIEF.md
# Four-Way Priority Bus Arbiter

This block decides which of four devices may drive a shared bus in each clock period. Every device raises its own request line when it wants the bus. The arbiter answers with four grant lines, and at most one of them is high at any time. When several devices ask at once, the device with the lowest index wins.

The arbiter is a Moore machine with five states: an idle state with no owner, and one ownership state for each device. The grants are decoded from the state register alone. A grant therefore appears in the clock period after the edge that sampled the request.

A build-time parameter selects the ownership policy:
- **Preemptive:** a better-placed request takes the bus from the current owner at the next edge.
- **Hold:** the owner keeps the bus until it lowers its own request line.

Top module: `bus_arbiter`

## Requirements
- R1: A clock edge with `rst` high puts the arbiter in the idle state, so all grants are 0 in the following period, whatever the requests are.
- R2: At most one bit of `gnt` is 1 in any clock period.
- R3: `gnt[i]` is 1 in a period only if `req[i]` was 1 at the clock edge that began that period.
- R4: When all request lines are 0 at an edge, all grants are 0 after that edge.
- R5: From idle, the requester with the lowest index among those active at the edge is granted.
- R6: With `PREEMPT`=1, whenever any request is active at an edge, the grant after that edge goes to the lowest active index, even if another device held the bus.
- R7: With `PREEMPT`=0, an owner whose request is still 1 at an edge keeps its grant, even while lower-index devices are requesting.
- R8: When the owner's request is 0 at an edge and other requests are active, the lowest active index is granted directly after that edge, with no idle period between the two owners.
- R9: Grants depend only on the state register. A change of `req` between clock edges leaves `gnt` unchanged until the next edge.
- R10: Bit i of `gnt` belongs to the device on bit i of `req`. Index 0 is the highest priority and index 3 the lowest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request lines, one per device; bit 0 has the highest priority |
| gnt | output | 4 | Grant lines, one-hot or all zero, decoded from state |

## Verification
The embedded properties assume that `req` holds known values at every rising edge and changes only between edges. They also assume that reset is applied before the first checked edge, so that the history seen by `$past` starts from a defined idle state.

The stimulus meets both assumptions:
- It drives requests and reset only at falling edges.
- It starts with several reset cycles, including one with every request raised.
- It then runs scripted handoff, preemption and hold sequences, followed by a pseudo-random request stream.

Two instances, one for each policy, see the same stimulus, so both policies are checked against the same reference model.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  localparam int NUM_DEV = 4;
  localparam int IDX_W   = $clog2(NUM_DEV);

  // Top bit marks ownership; low bits carry the owner index.
  typedef enum logic [IDX_W:0] {
    ST_IDLE = 3'b000,
    ST_OWN0 = 3'b100,
    ST_OWN1 = 3'b101,
    ST_OWN2 = 3'b110,
    ST_OWN3 = 3'b111
  } arbState_t;

  // Strobes from control to the grant datapath.
  typedef struct packed {
    logic             busy;
    logic [IDX_W-1:0] owner;
  } grantCtl_t;

  // Lowest set index wins; scanning downward leaves it as the final value.
  function automatic logic [IDX_W-1:0] lowestIdx(input logic [NUM_DEV-1:0] r);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (r[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter bit PREEMPT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  output grantCtl_t          ctl
);

  arbState_t        curState, nxtState;
  logic             anyReq;
  logic [IDX_W-1:0] winIdx;
  logic             ownerHolds;

  always_comb begin
    anyReq     = |req;
    winIdx     = lowestIdx(req);
    ownerHolds = 1'b0;
    case (curState)
      ST_OWN0: ownerHolds = req[0];
      ST_OWN1: ownerHolds = req[1];
      ST_OWN2: ownerHolds = req[2];
      ST_OWN3: ownerHolds = req[3];
      default: ownerHolds = 1'b0;
    endcase
  end

  // Policy is fixed at build time; only the selected branch is generated.
  generate
    if (PREEMPT) begin : g_preempt
      always_comb begin
        if (anyReq) nxtState = arbState_t'({1'b1, winIdx});
        else        nxtState = ST_IDLE;
      end
    end else begin : g_hold
      always_comb begin
        if (ownerHolds)  nxtState = curState;
        else if (anyReq) nxtState = arbState_t'({1'b1, winIdx});
        else             nxtState = ST_IDLE;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  assign ctl.busy  = curState[IDX_W];
  assign ctl.owner = curState[IDX_W-1:0];

  // R4
  idle_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (curState == ST_IDLE));

  // R7
  hold_keeps_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (!PREEMPT && curState[IDX_W] && req[curState[IDX_W-1:0]]) |=> $stable(curState));

  // R6
  preempt_best_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (PREEMPT && (req != '0)) |=>
      (curState[IDX_W] && (curState[IDX_W-1:0] == lowestIdx($past(req)))));

  // R8
  handoff_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (curState[IDX_W] && !req[curState[IDX_W-1:0]] && (req != '0)) |=> curState[IDX_W]);

endmodule

// File: rtl/bus_arb_grant.sv
module bus_arb_grant
  import bus_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  input  grantCtl_t          ctl,
  output logic [NUM_DEV-1:0] gnt
);

  generate
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dec
      assign gnt[i] = ctl.busy && (ctl.owner == IDX_W'(i));

      // R3
      grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        gnt[i] |-> $past(req[i]));
    end
  endgenerate

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter bit PREEMPT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  output logic [NUM_DEV-1:0] gnt
);

  grantCtl_t ctl;

  bus_arb_ctrl #(.PREEMPT(PREEMPT)) ctrl_i (
    .clk (clk),
    .rst (rst),
    .req (req),
    .ctl (ctl)
  );

  bus_arb_grant grant_i (
    .clk (clk),
    .rst (rst),
    .req (req),
    .ctl (ctl),
    .gnt (gnt)
  );

endmodule

// File: tb/bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'b0000;
  logic [3:0] gntHold, gntPre;

  always #4 clk = ~clk;

  bus_arbiter #(.PREEMPT(1'b0)) dut_i (
    .clk (clk), .rst (rst), .req (req), .gnt (gntHold)
  );

  bus_arbiter #(.PREEMPT(1'b1)) dutPre_i (
    .clk (clk), .rst (rst), .req (req), .gnt (gntPre)
  );

  typedef struct {
    logic [3:0] expHold;
    logic [3:0] expPre;
    logic [3:0] reqSeen;
    string      tag;
  } item_t;

  item_t      sbQ[$];
  int         errors = 0;
  int         checks = 0;
  int         ownHold = -1;
  int         ownPre  = -1;
  bit         done = 0;
  logic [7:0] lfsr = 8'h5a;

  // Reference model: the owner index after one edge, or -1 for idle.
  function automatic int nextOwner(int own, logic [3:0] r, bit pre, logic rs);
    int best;
    best = -1;
    for (int i = 3; i >= 0; i--) if (r[i]) best = i;
    if (rs) return -1;
    if (!pre && own >= 0 && r[own]) return own;
    return best;
  endfunction

  function automatic logic [3:0] toGnt(int own);
    return (own < 0) ? 4'b0000 : (4'b0001 << own);
  endfunction

  task automatic check4(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: applies stimulus at the falling edge and queues the expectation.
  task automatic drive(logic [3:0] r, logic rs, string tag);
    item_t it;
    @(negedge clk);
    req = r;
    rst = rs;
    ownHold = nextOwner(ownHold, r, 1'b0, rs);
    ownPre  = nextOwner(ownPre,  r, 1'b1, rs);
    it.expHold = toGnt(ownHold);
    it.expPre  = toGnt(ownPre);
    it.reqSeen = r;
    it.tag     = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compares the grants after each rising edge, then checks that
  // they stay stable across the falling-edge request change (R9).
  initial begin
    logic [3:0] snapHold, snapPre;
    forever begin
      @(posedge clk);
      #2;
      snapHold = gntHold;
      snapPre  = gntPre;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        check4(it.tag, "hold gnt", gntHold, it.expHold);
        check4(it.tag, "preempt gnt", gntPre, it.expPre);
        // R2: at most one grant
        check4("R2", "hold onehot0", 4'($onehot0(gntHold)), 4'd1);
        check4("R2", "preempt onehot0", 4'($onehot0(gntPre)), 4'd1);
        // R3: no grant without a request
        check4("R3", "hold gnt&~req", gntHold & ~it.reqSeen, 4'b0000);
        check4("R3", "preempt gnt&~req", gntPre & ~it.reqSeen, 4'b0000);
      end
      @(negedge clk);
      #1;
      check4("R9", "hold stable", gntHold, snapHold);
      check4("R9", "preempt stable", gntPre, snapPre);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset wins even with every request raised
    drive(4'b0000, 1'b1, "R1");
    drive(4'b1111, 1'b1, "R1");
    drive(4'b0000, 1'b0, "R4");
    drive(4'b0100, 1'b0, "R5");
    drive(4'b0110, 1'b0, "R6 R7");
    drive(4'b0111, 1'b0, "R6 R7");
    drive(4'b0011, 1'b0, "R8");
    drive(4'b0010, 1'b0, "R8");
    drive(4'b1010, 1'b0, "R7 R10");
    drive(4'b1000, 1'b0, "R8 R10");
    drive(4'b1001, 1'b0, "R6 R7");
    drive(4'b0000, 1'b0, "R4");
    drive(4'b1111, 1'b0, "R5 R10");
    drive(4'b1110, 1'b0, "R8");
    drive(4'b1100, 1'b0, "R8");
    drive(4'b1000, 1'b0, "R8");
    drive(4'b0000, 1'b0, "R4");
    drive(4'b1000, 1'b0, "R5");
    drive(4'b1111, 1'b1, "R1");
    drive(4'b0000, 1'b0, "R4");
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[3:0], 1'b0, "R5 R6 R7 R8");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule